// File: doc/BRIEF.md
# Timed-Access ROM Size Controller

This block holds the setting that says how much of the program address space is served by on-chip ROM. It protects that setting behind a two-byte unlock written to a timed-access register. It watches a simple single-cycle special-function-register (SFR) write bus. A write to the size register changes the 3-bit setting only when it follows the unlock pair `AAh`, `55h` within a short window. At all other times the write is dropped.

The current setting is decoded into a byte limit. For every program fetch address, the block says whether the fetch goes to internal ROM or to the external bus. The 0 kB setting is a special case: every fetch is routed externally, including fetches from the lower 1 kB that holds the interrupt vectors.

After an accepted update, a pending flag stays high while the new setting settles. The flag lasts for two machine cycles, counted on a machine-cycle strobe input. The reset deassertion edge is assumed to be synchronised to `clk` by the chip's reset logic.

Top module: `rom_window_ctl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the setting is the device default (code 7, 64 kB). `rom_limit` is 65536, `size_pending` is 0 and fetch address FFFFh is routed internally.
- R2: `rom_limit` decodes `size_sel` as follows. Code 0 gives 0. Code n from 1 to 7 gives 1024·2^(n-1) bytes, so code 7 gives 65536.
- R3: A fetch address below `rom_limit` gives `fetch_ext`=0. An address at or above it gives `fetch_ext`=1.
- R4: With code 0, `fetch_ext` is 1 for every address, including 0000h–03FFh.
- R5: An unlock is a write of `AAh` to SFR address C7h followed by a write of `55h` to C7h. A later write to the size register at SFR address C2h loads bits [2:0] of the data into the setting.
- R6: The unlock window covers the 3 clock cycles after the cycle of the `55h` write. A size write in the 4th cycle after it is dropped, and so is a second size write after an accepted one.
- R7: The unlock sequence restarts on any other C7h write. This covers a non-`AAh` first byte, a non-`55h` second byte, and an `AAh` while the window is open. A repeated `AAh` counts as a fresh first byte.
- R8: A size-register write without an open window leaves `size_sel` unchanged and does not raise `size_pending`.
- R9: `size_pending` rises in the cycle after an accepted size write. It falls after exactly two further clock edges on which `mc_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_wr | input | 1 | SFR write strobe, one cycle per write |
| sfr_addr | input | 8 | SFR write address |
| sfr_wdata | input | 8 | SFR write data |
| mc_tick | input | 1 | Machine-cycle strobe |
| fetch_addr | input | ADDR_W | Program fetch address to route |
| size_sel | output | 3 | Current size code |
| rom_limit | output | ADDR_W+1 | On-chip ROM limit in bytes |
| fetch_ext | output | 1 | 1: fetch goes to external memory |
| size_pending | output | 1 | New setting still settling |

## Verification
The checker tests these properties on every cycle:
- a changed setting or a rising pending flag is always preceded by a size-register write;
- the pending flag only falls after a machine-cycle strobe;
- the limit is zero or a single power of two, and is zero exactly for code 0;
- a fetch routed internally always lies below the limit, and a zero limit forces external routing.

Some behaviour only shows up in the bench's scenarios:
- the exact unlock ordering and its restart rules;
- the three-cycle window edge and its closing after one accepted write;
- the full decode table;
- the exact two-tick settling length.

// File: rtl/romsel_pkg.sv
package romsel_pkg;
  localparam int SEL_W = 3;
  typedef logic [SEL_W-1:0] sel_t;
  typedef enum logic [1:0] {UNL_IDLE, UNL_HALF, UNL_OPEN} unl_state_e;
endpackage

// File: rtl/unlock_seq.sv
module unlock_seq
  import romsel_pkg::*;
#(
  parameter logic [7:0] TA_ADDR = 8'hC7,
  parameter logic [7:0] KEY1    = 8'hAA,
  parameter logic [7:0] KEY2    = 8'h55,
  parameter int         WINDOW  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  input  logic       consume,
  output logic       open
);
  localparam int CW = $clog2(WINDOW + 1);

  unl_state_e     st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           ta_wr;

  assign ta_wr = wr && (addr == TA_ADDR);

  // next state
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (st_q == UNL_OPEN) begin
      if (cnt_q != '0) cnt_d = cnt_q - CW'(1);
      if (consume || cnt_q == CW'(1)) begin
        st_d  = UNL_IDLE;
        cnt_d = '0;
      end
    end
    if (ta_wr) begin
      cnt_d = '0;
      if (wdata == KEY1) begin
        st_d = UNL_HALF;
      end else if (st_q == UNL_HALF && wdata == KEY2) begin
        st_d  = UNL_OPEN;
        cnt_d = CW'(WINDOW);
      end else begin
        st_d = UNL_IDLE;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= UNL_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign open = (st_q == UNL_OPEN);
endmodule

// File: rtl/sel_store.sv
module sel_store
  import romsel_pkg::*;
#(
  parameter sel_t DEFAULT_SEL = 3'b111,
  parameter int   SETTLE      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  sel_t new_sel,
  input  logic mc_tick,
  output sel_t sel,
  output logic pending
);
  localparam int PW = $clog2(SETTLE + 1);

  sel_t          sel_q;
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          pcnt_en;

  // next state
  always_comb begin
    pcnt_d  = pcnt_q;
    pcnt_en = 1'b0;
    if (load) begin
      pcnt_d  = PW'(SETTLE);
      pcnt_en = 1'b1;
    end else if (mc_tick && pcnt_q != '0) begin
      pcnt_d  = pcnt_q - PW'(1);
      pcnt_en = 1'b1;
    end
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel_q <= DEFAULT_SEL;
    else if (load) sel_q <= new_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (pcnt_en) pcnt_q <= pcnt_d;
  end

  assign sel     = sel_q;
  assign pending = (pcnt_q != '0);
endmodule

// File: rtl/fetch_router.sv
module fetch_router
  import romsel_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BASE_LOG2 = 10
) (
  input  sel_t              sel,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [ADDR_W:0]   limit,
  output logic              ext
);
  localparam int LW = ADDR_W + 1;

  logic force_ext;

  always_comb begin
    force_ext = (sel == '0);
    limit     = force_ext ? '0 : (LW'(1) << (BASE_LOG2 - 1 + int'(sel)));
  end

  // code 0 sends everything out, vector area included
  assign ext = force_ext || ({1'b0, fetch_addr} >= limit);
endmodule

// File: rtl/rom_window_ctl.sv
module rom_window_ctl
  import romsel_pkg::*;
#(
  parameter int         ADDR_W        = 16,
  parameter logic [7:0] TA_ADDR       = 8'hC7,
  parameter logic [7:0] SIZE_ADDR     = 8'hC2,
  parameter logic [2:0] DEFAULT_SEL   = 3'b111,
  parameter int         UNLOCK_WINDOW = 3,
  parameter int         SETTLE_MC     = 2,
  parameter int         BASE_LOG2     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfr_wr,
  input  logic [7:0]        sfr_addr,
  input  logic [7:0]        sfr_wdata,
  input  logic              mc_tick,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [2:0]        size_sel,
  output logic [ADDR_W:0]   rom_limit,
  output logic              fetch_ext,
  output logic              size_pending
);
  logic win_open;
  logic size_load;
  sel_t sel_w;

  assign size_load = sfr_wr && (sfr_addr == SIZE_ADDR) && win_open;

  unlock_seq #(
    .TA_ADDR(TA_ADDR), .KEY1(8'hAA), .KEY2(8'h55), .WINDOW(UNLOCK_WINDOW)
  ) u_unlock (
    .clk(clk), .rst_n(rst_n), .wr(sfr_wr), .addr(sfr_addr),
    .wdata(sfr_wdata), .consume(size_load), .open(win_open)
  );

  sel_store #(
    .DEFAULT_SEL(DEFAULT_SEL), .SETTLE(SETTLE_MC)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .load(size_load), .new_sel(sfr_wdata[SEL_W-1:0]),
    .mc_tick(mc_tick), .sel(sel_w), .pending(size_pending)
  );

  fetch_router #(
    .ADDR_W(ADDR_W), .BASE_LOG2(BASE_LOG2)
  ) u_router (
    .sel(sel_w), .fetch_addr(fetch_addr), .limit(rom_limit), .ext(fetch_ext)
  );

  assign size_sel = sel_w;
endmodule

// File: rtl/rom_window_ctl_chk.sv
module rom_window_ctl_chk #(
  parameter int         ADDR_W      = 16,
  parameter logic [7:0] SIZE_ADDR   = 8'hC2,
  parameter logic [2:0] DEFAULT_SEL = 3'b111
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sfr_wr,
  input logic [7:0]        sfr_addr,
  input logic              mc_tick,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [2:0]        size_sel,
  input logic [ADDR_W:0]   rom_limit,
  input logic              fetch_ext,
  input logic              size_pending
);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |-> (size_sel == DEFAULT_SEL && !size_pending));

  assert_limit_pow2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rom_limit) <= 1);

  assert_zero_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (size_sel == 3'd0) == (rom_limit == '0));

  assert_internal_below_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_ext |-> ({1'b0, fetch_addr} < rom_limit));

  assert_zero_all_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_limit == '0) |-> fetch_ext);

  assert_change_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (size_sel != $past(size_sel)) |-> $past(sfr_wr && sfr_addr == SIZE_ADDR));

  assert_pending_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(size_pending) |-> $past(sfr_wr && sfr_addr == SIZE_ADDR));

  assert_pending_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(size_pending) |-> $past(mc_tick));
endmodule

bind rom_window_ctl rom_window_ctl_chk #(
  .ADDR_W(ADDR_W), .SIZE_ADDR(SIZE_ADDR), .DEFAULT_SEL(DEFAULT_SEL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
  .mc_tick(mc_tick), .fetch_addr(fetch_addr), .size_sel(size_sel),
  .rom_limit(rom_limit), .fetch_ext(fetch_ext), .size_pending(size_pending)
);

// File: tb/tb_rom_window_ctl.sv
module tb_rom_window_ctl;
  localparam logic [7:0] TA = 8'hC7;
  localparam logic [7:0] SZ = 8'hC2;
  localparam int NV = 16;
  // {code, fetch address, expected fetch_ext}
  localparam logic [19:0] VECS [NV] = '{
    {3'd1, 16'h03FF, 1'b0}, {3'd1, 16'h0400, 1'b1},
    {3'd2, 16'h07FF, 1'b0}, {3'd2, 16'h0800, 1'b1},
    {3'd3, 16'h0FFF, 1'b0}, {3'd3, 16'h1000, 1'b1},
    {3'd4, 16'h1FFF, 1'b0}, {3'd4, 16'h2000, 1'b1},
    {3'd5, 16'h3FFF, 1'b0}, {3'd5, 16'h4000, 1'b1},
    {3'd6, 16'h7FFF, 1'b0}, {3'd6, 16'h8000, 1'b1},
    {3'd0, 16'h0000, 1'b1}, {3'd0, 16'h03FF, 1'b1},
    {3'd7, 16'hFFFF, 1'b0}, {3'd7, 16'h0000, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sfr_wr;
  logic [7:0]  sfr_addr;
  logic [7:0]  sfr_wdata;
  logic        mc_tick;
  logic [15:0] fetch_addr;
  logic [2:0]  size_sel;
  logic [16:0] rom_limit;
  logic        fetch_ext;
  logic        size_pending;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rom_window_ctl dut (
    .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .mc_tick(mc_tick), .fetch_addr(fetch_addr),
    .size_sel(size_sel), .rom_limit(rom_limit), .fetch_ext(fetch_ext),
    .size_pending(size_pending)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  task automatic unlock();
    wr(TA, 8'hAA);
    wr(TA, 8'h55);
  endtask

  task automatic set_size(input logic [2:0] c);
    unlock();
    wr(SZ, {5'd0, c});
    repeat (3) @(negedge clk);
  endtask

  function automatic int exp_limit(input int c);
    return (c == 0) ? 0 : (1024 << (c - 1));
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b1; sfr_wr = 1'b0; sfr_addr = 8'h00; sfr_wdata = 8'h00;
    mc_tick = 1'b1; fetch_addr = 16'hFFFF;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 sel in reset", size_sel, 7);
    chk("R1 limit in reset", rom_limit, 65536);
    chk("R1 pending in reset", size_pending, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sel after release", size_sel, 7);
    chk("R1 FFFFh internal", fetch_ext, 0);

    // R2 R3 R4 R5: table walk, each new code through a full unlock
    for (int i = 0; i < NV; i++) begin
      if (VECS[i][19:17] != size_sel) set_size(VECS[i][19:17]);
      chk("R5 code loaded", size_sel, int'(VECS[i][19:17]));
      fetch_addr = VECS[i][16:1];
      #1;
      chk("R2 limit decode", rom_limit, exp_limit(int'(VECS[i][19:17])));
      chk(VECS[i][19:17] == 3'd0 ? "R4 zero kB routing" : "R3 routing",
          fetch_ext, int'(VECS[i][0]));
    end

    // R6: window edge, k idle cycles between 55h and size write
    for (int k = 0; k < 4; k++) begin
      set_size(3'd7);
      unlock();
      repeat (k) @(negedge clk);
      wr(SZ, 8'h02);
      chk("R6 window edge", size_sel, (k < 3) ? 2 : 7);
    end
    // R6: window closes after one accepted write
    unlock();
    wr(SZ, 8'h03);
    wr(SZ, 8'h05);
    chk("R6 second write dropped", size_sel, 3);
    repeat (3) @(negedge clk);

    // R7: broken sequences
    wr(TA, 8'hAA); wr(TA, 8'h00); wr(TA, 8'h55); wr(SZ, 8'h01);
    chk("R7 bad second byte", size_sel, 3);
    wr(TA, 8'h55); wr(SZ, 8'h01);
    chk("R7 lone 55h", size_sel, 3);
    wr(TA, 8'hAA); wr(TA, 8'hAA); wr(TA, 8'h55); wr(SZ, 8'h04);
    chk("R7 repeated AAh restarts", size_sel, 4);
    repeat (3) @(negedge clk);
    unlock(); wr(TA, 8'hAA); wr(SZ, 8'h06);
    chk("R7 AAh closes window", size_sel, 4);

    // R8: write with no unlock
    wr(SZ, 8'h01);
    chk("R8 locked write sel", size_sel, 4);
    chk("R8 locked write pending", size_pending, 0);

    // R9: settling with mc_tick every cycle
    unlock();
    wr(SZ, 8'h05);
    chk("R9 pending after load", size_pending, 1);
    @(negedge clk);
    chk("R9 pending one tick", size_pending, 1);
    @(negedge clk);
    chk("R9 pending after two ticks", size_pending, 0);
    // R9: sparse ticks
    mc_tick = 1'b0;
    unlock();
    wr(SZ, 8'h06);
    repeat (3) @(negedge clk);
    chk("R9 no tick holds pending", size_pending, 1);
    mc_tick = 1'b1; @(negedge clk); mc_tick = 1'b0;
    chk("R9 one of two ticks", size_pending, 1);
    mc_tick = 1'b1; @(negedge clk); mc_tick = 1'b0;
    chk("R9 second tick clears", size_pending, 0);
    mc_tick = 1'b1;

    // R1: reset mid-run restores default
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset sel", size_sel, 7);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mid-run reset limit", rom_limit, 65536);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule